// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block decides, once per cycle, which of several hardware threads may fetch into an out-of-order back end that all threads share. For every thread it keeps a count of instructions in flight: the count goes up by the number of entries the thread allocates and down by the number it retires or squashes. The selector uses these counts together with the per-thread fetch requests to produce a registered one-hot grant. The grant can be empty.

Two independent controls choose the behaviour. The first is the selection policy. In rotating mode the grant moves around the requesting threads in turn. In fewest-in-flight mode the requesting thread with the smallest count wins, and a rotating priority pointer breaks ties. The second control is the partitioning mode. With fixed partitioning each thread gets an equal slice of the instruction window, and a thread that has filled its slice cannot be granted. With shared partitioning all threads draw from the whole window and no thread has its own limit. In both modes no grant is issued while the whole window is full. The window storage itself lives outside this block. The counts are exported so that the neighbouring rename and allocation logic can see them.

Top module: `fetch_thread_sel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `grant` is all zeros and every field of `thr_occ` is zero. Reset also sets the priority pointer to thread 0.
- R2: In the cycle after the inputs are presented, each thread's count becomes old + alloc − free, using the thread's `AW`-bit field at bit offset t·AW in `alloc_cnt` and `free_cnt`. The result is clamped to 0 at the bottom and to `WIN` at the top. Field t of `thr_occ` sits at bit offset t·OCC_W.
- R3: `grant` is registered. Its value in a cycle is computed from the requests, modes and counts of the previous cycle. It has at most one bit set, and that bit belongs to a thread that was requesting.
- R4: When `use_icount`=0, the grant goes to the first eligible thread found by scanning upward from the priority pointer and wrapping around. After a grant to thread g, the pointer becomes g+1 modulo NTHR.
- R5: When `use_icount`=1, the grant goes to the eligible thread whose count is strictly the smallest.
- R6: When `use_icount`=1 and several eligible threads share the smallest count, the one reached first when scanning from the priority pointer wins. Because the pointer then advances, threads with equal counts take turns.
- R7: When `cap_static`=1, a thread whose count is at least WIN/NTHR is not eligible.
- R8: When `cap_static`=0, a thread may be granted at any count, even above WIN/NTHR.
- R9: When the sum of all counts is at least `WIN`, no grant is issued, whatever the requests.
- R10: When no thread is eligible, `grant` is all zeros and the priority pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | NTHR | Per-thread fetch request |
| alloc_cnt | input | NTHR*AW | Per-thread count of entries allocated this cycle |
| free_cnt | input | NTHR*AW | Per-thread count of entries retired or squashed this cycle |
| use_icount | input | 1 | 0: rotating selection, 1: fewest-in-flight selection |
| cap_static | input | 1 | 1: fixed equal share per thread, 0: shared window |
| grant | output | NTHR | Registered one-hot fetch grant |
| thr_occ | output | NTHR*OCC_W | Per-thread in-flight counts |

## Verification
The bench aims first at ties in fewest-in-flight mode. A design that ignores the pointer there would always pick the lowest-numbered thread, so one thread would never get a turn. It also drives a thread past its fixed share and then flips between fixed and shared modes. A missing cap would grant the over-share thread in fixed mode, and a cap applied in both modes would starve that thread in shared mode. It fills the window so that the total reaches capacity, where a design with an off-by-one full test would still grant. It retires more entries than a thread holds, and allocates into a thread that is already at `WIN`, where a counter without clamping would wrap around.

// File: rtl/fetch_sel_pkg.sv
package fetch_sel_pkg;

    typedef enum logic {
        POL_ROTATE = 1'b0,
        POL_FEWEST = 1'b1
    } fetch_pol_e;

    typedef enum logic {
        PART_SHARED = 1'b0,
        PART_FIXED  = 1'b1
    } part_mode_e;

    // Index reached after `step` positions from `base` in a ring of `n`.
    function automatic int ring_idx(input int base, input int step, input int n);
        int r;
        r = base + step;
        if (r >= n) r = r - n;
        return r;
    endfunction

endpackage

// File: rtl/occ_counter.sv
module occ_counter #(
    parameter int WIN = 32,
    parameter int AW  = 3,
    parameter int CW  = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] add_n,
    input  logic [AW-1:0] sub_n,
    output logic [CW-1:0] occ
);
    localparam int EW = ((CW > AW) ? CW : AW) + 2;

    logic [EW-1:0] sum_ext;
    logic [EW-1:0] occ_nxt;

    always_comb begin
        sum_ext = EW'(occ) + EW'(add_n);
        if (sum_ext < EW'(sub_n))
            occ_nxt = '0;
        else if ((sum_ext - EW'(sub_n)) > EW'(WIN))
            occ_nxt = EW'(WIN);
        else
            occ_nxt = sum_ext - EW'(sub_n);
    end

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= occ_nxt[CW-1:0];
    end

endmodule

// File: rtl/fetch_pick.sv
module fetch_pick
    import fetch_sel_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int CW   = 6,
    parameter int IW   = 2
) (
    input  logic [NTHR-1:0]    elig,
    input  logic [NTHR*CW-1:0] occ_flat,
    input  logic [IW-1:0]      ptr,
    input  fetch_pol_e         pol,
    output logic               pick_vld,
    output logic [IW-1:0]      pick_idx
);
    logic [CW-1:0] best_occ;
    logic [CW-1:0] cand_occ;

    always_comb begin
        pick_vld = 1'b0;
        pick_idx = '0;
        best_occ = '0;
        cand_occ = '0;
        for (int k = 0; k < NTHR; k++) begin
            int i;
            i = ring_idx(int'(ptr), k, NTHR);
            cand_occ = occ_flat[i*CW +: CW];
            if (elig[i] && (!pick_vld ||
                            (pol == POL_FEWEST && cand_occ < best_occ))) begin
                pick_vld = 1'b1;
                pick_idx = IW'(i);
                best_occ = cand_occ;
            end
        end
    end

endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
    import fetch_sel_pkg::*;
#(
    parameter int NTHR  = 4,
    parameter int WIN   = 32,
    parameter int AW    = 3,
    parameter int OCC_W = $clog2(WIN + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NTHR-1:0]       fetch_req,
    input  logic [NTHR*AW-1:0]    alloc_cnt,
    input  logic [NTHR*AW-1:0]    free_cnt,
    input  logic                  use_icount,
    input  logic                  cap_static,
    output logic [NTHR-1:0]       grant,
    output logic [NTHR*OCC_W-1:0] thr_occ
);
    localparam int IW    = (NTHR > 1) ? $clog2(NTHR) : 1;
    localparam int TW    = OCC_W + IW + 1;
    localparam int SHARE = WIN / NTHR;

    fetch_pol_e       pol;
    part_mode_e       part;
    logic [TW-1:0]    total_occ;
    logic             win_full;
    logic [NTHR-1:0]  elig;
    logic [IW-1:0]    ptr;
    logic             pick_vld;
    logic [IW-1:0]    pick_idx;

    assign pol  = fetch_pol_e'(use_icount);
    assign part = part_mode_e'(cap_static);

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        occ_counter #(
            .WIN (WIN),
            .AW  (AW),
            .CW  (OCC_W)
        ) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .add_n (alloc_cnt[t*AW +: AW]),
            .sub_n (free_cnt[t*AW +: AW]),
            .occ   (thr_occ[t*OCC_W +: OCC_W])
        );

        assign elig[t] = fetch_req[t] && !win_full &&
                         (part == PART_SHARED ||
                          thr_occ[t*OCC_W +: OCC_W] < OCC_W'(SHARE));
    end

    always_comb begin
        total_occ = '0;
        for (int t = 0; t < NTHR; t++)
            total_occ = total_occ + TW'(thr_occ[t*OCC_W +: OCC_W]);
    end

    assign win_full = (total_occ >= TW'(WIN));

    fetch_pick #(
        .NTHR (NTHR),
        .CW   (OCC_W),
        .IW   (IW)
    ) u_pick (
        .elig     (elig),
        .occ_flat (thr_occ),
        .ptr      (ptr),
        .pol      (pol),
        .pick_vld (pick_vld),
        .pick_idx (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant <= '0;
            ptr   <= '0;
        end else if (pick_vld) begin
            grant <= NTHR'(1) << pick_idx;
            ptr   <= (pick_idx == IW'(NTHR - 1)) ? '0 : pick_idx + IW'(1);
        end else begin
            grant <= '0;
        end
    end

endmodule

// File: rtl/fetch_sel_chk.sv
module fetch_sel_chk #(
    parameter int NTHR  = 4,
    parameter int WIN   = 32,
    parameter int OCC_W = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NTHR-1:0]       fetch_req,
    input logic                  cap_static,
    input logic [NTHR-1:0]       grant,
    input logic [NTHR*OCC_W-1:0] thr_occ
);
    localparam int SHARE = WIN / NTHR;

    int occ_sum;
    always_comb begin
        occ_sum = 0;
        for (int t = 0; t < NTHR; t++)
            occ_sum = occ_sum + int'(thr_occ[t*OCC_W +: OCC_W]);
    end

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R9
    full_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (occ_sum >= WIN) |=> (grant == '0));

    for (genvar t = 0; t < NTHR; t++) begin : g_chk
        // R3
        grant_req_chk: assert property (@(posedge clk) disable iff (rst)
            grant[t] |-> $past(fetch_req[t]));

        // R7
        share_cap_chk: assert property (@(posedge clk) disable iff (rst)
            (grant[t] && $past(cap_static)) |->
                ($past(thr_occ[t*OCC_W +: OCC_W]) < OCC_W'(SHARE)));

        // R2
        occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
            thr_occ[t*OCC_W +: OCC_W] <= OCC_W'(WIN));
    end

endmodule

bind fetch_thread_sel fetch_sel_chk #(
    .NTHR  (NTHR),
    .WIN   (WIN),
    .OCC_W (OCC_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_req  (fetch_req),
    .cap_static (cap_static),
    .grant      (grant),
    .thr_occ    (thr_occ)
);

// File: tb/tb_fetch_thread_sel.sv
`timescale 1ns/1ps
module tb_fetch_thread_sel;
    localparam int NTHR  = 4;
    localparam int WIN   = 32;
    localparam int AW    = 3;
    localparam int CW    = 6;
    localparam int SHARE = WIN / NTHR;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NTHR-1:0]      fetch_req = '0;
    logic [NTHR*AW-1:0]   alloc_cnt = '0;
    logic [NTHR*AW-1:0]   free_cnt = '0;
    logic                 use_icount = 1'b0;
    logic                 cap_static = 1'b0;
    logic [NTHR-1:0]      grant;
    logic [NTHR*CW-1:0]   thr_occ;

    int n_run  = 0;
    int n_fail = 0;
    int m_occ[NTHR];
    int m_ptr;

    always #2 clk = ~clk;

    fetch_thread_sel #(.NTHR(NTHR), .WIN(WIN), .AW(AW), .OCC_W(CW)) dut (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .alloc_cnt(alloc_cnt),
        .free_cnt(free_cnt), .use_icount(use_icount), .cap_static(cap_static),
        .grant(grant), .thr_occ(thr_occ));

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [NTHR*AW-1:0] fld(input int t, input int v);
        return (NTHR*AW)'(v) << (t*AW);
    endfunction

    function automatic logic [NTHR*AW-1:0] all_fld(input int v);
        logic [NTHR*AW-1:0] r = '0;
        for (int t = 0; t < NTHR; t++) r |= fld(t, v);
        return r;
    endfunction

    task automatic step(input logic [NTHR-1:0] req, input logic [NTHR*AW-1:0] al,
                        input logic [NTHR*AW-1:0] fr, input logic ic, input logic st,
                        input string tag);
        int tot, pick, best, nocc[NTHR];
        logic [NTHR-1:0] eg;
        @(negedge clk);
        fetch_req = req; alloc_cnt = al; free_cnt = fr;
        use_icount = ic; cap_static = st;
        tot = 0;
        for (int t = 0; t < NTHR; t++) tot += m_occ[t];
        pick = -1; best = 0;
        for (int k = 0; k < NTHR; k++) begin
            int i = (m_ptr + k) % NTHR;
            bit ok = req[i] && tot < WIN && (!st || m_occ[i] < SHARE);
            if (ok && (pick < 0 || (ic && m_occ[i] < best))) begin
                pick = i; best = m_occ[i];
            end
        end
        eg = (pick < 0) ? '0 : NTHR'(1) << pick;
        for (int t = 0; t < NTHR; t++) begin
            int v = m_occ[t] + int'(al[t*AW +: AW]) - int'(fr[t*AW +: AW]);
            if (v < 0) v = 0;
            if (v > WIN) v = WIN;
            nocc[t] = v;
        end
        @(posedge clk);
        #1;
        check(tag, int'(grant), int'(eg));
        check("R3 grant to requester, one-hot",
              int'($onehot0(grant) && ((grant & ~req) == '0)), 1);
        for (int t = 0; t < NTHR; t++) begin
            check("R2 count update", int'(thr_occ[t*CW +: CW]), nocc[t]);
            m_occ[t] = nocc[t];
        end
        if (pick >= 0) m_ptr = (pick + 1) % NTHR;
    endtask

    initial begin
        #(4ns * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_ptr = 0;
        for (int t = 0; t < NTHR; t++) m_occ[t] = 0;
        fetch_req = '1; alloc_cnt = all_fld(3);
        repeat (3) @(posedge clk);
        #1;
        check("R1 grant in reset", int'(grant), 0);
        check("R1 counts in reset", int'(thr_occ), 0);
        @(negedge clk);
        rst = 1'b0; fetch_req = '0; alloc_cnt = '0;
        #1;
        check("R1 grant after reset", int'(grant), 0);
        check("R1 counts after reset", int'(thr_occ), 0);

        // R8: thread 0 above its share still fetches in shared mode
        step('0, fld(0, 5), '0, 1'b1, 1'b0, "R10 no requester");
        step('0, fld(0, 5), '0, 1'b1, 1'b0, "R10 no requester");
        step(4'b0001, '0, '0, 1'b1, 1'b0, "R8 over share in shared mode");
        // R7: same thread blocked in fixed mode, thread 1 still served
        step(4'b0001, '0, '0, 1'b1, 1'b1, "R7 over share blocked");
        step(4'b0011, '0, '0, 1'b1, 1'b1, "R7 under share served");
        // R5: fewest in flight wins
        step('0, fld(2, 3) | fld(3, 1), '0, 1'b1, 1'b0, "R10 idle");
        step(4'b1101, '0, '0, 1'b1, 1'b0, "R5 fewest wins");
        // R6: drain all, equal counts alternate
        step('0, '0, all_fld(7), 1'b1, 1'b0, "R10 idle");
        step('0, '0, all_fld(7), 1'b1, 1'b0, "R2 clamp at zero");
        for (int k = 0; k < 6; k++)
            step(4'b1111, '0, '0, 1'b1, 1'b0, "R6 tie rotation");
        // R4: rotating over a sparse set
        for (int k = 0; k < 4; k++)
            step(4'b1010, '0, '0, 1'b0, 1'b0, "R4 rotate");
        // R9: fill window to capacity, then no grant
        for (int k = 0; k < 5; k++)
            step('0, all_fld(7), '0, 1'b0, 1'b0, "R10 idle");
        step(4'b1111, '0, '0, 1'b0, 1'b0, "R9 full window");
        step(4'b1111, '0, '0, 1'b1, 1'b0, "R9 full window");
        step('0, fld(0, 7), '0, 1'b0, 1'b0, "R2 clamp at top");
        step('0, '0, all_fld(7), 1'b0, 1'b0, "R10 idle");

        for (int n = 0; n < 3000; n++) begin
            logic [NTHR*AW-1:0] al, fr;
            logic ic, st;
            al = '0; fr = '0;
            for (int t = 0; t < NTHR; t++) begin
                al |= fld(t, int'($urandom % 4));
                fr |= fld(t, int'($urandom % 4));
            end
            ic = ((n / 40) % 2) == 1;
            st = ((n / 97) % 2) == 1;
            step(NTHR'($urandom), al, fr, ic, st, ic ? "R5 random fewest" : "R4 random rotate");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule